// File: doc/BRIEF.md
# Legacy Paravirtual Device Register Window

This block is the host-facing register file of a legacy paravirtual device. A host issues byte, halfword or word reads and writes at byte offsets inside a small I/O window. The window holds a fixed capability mask that the device offers and a feature mask that the driver accepts. It also holds a queue selector and, for the selected queue, a page frame number, a size and an interrupt vector. A device status byte, a read-to-clear interrupt cause byte and a configuration-change vector complete the common registers. Offsets above the common registers form a device-specific area. Accesses there are forwarded on a side port, rebased to zero, and the side port returns the read data.

Register accesses have side effects. Storing a zero page frame or a zero status puts the device back into its reset state. Reading the cause byte hands the cause to the host and empties it. Queue notifications are passed to the queue engine as a pulse. Events from the queue engine either raise a level interrupt line, when message interrupts are off, or leave as a one-cycle message request that carries the vector programmed for that event.

Top module: `vdev_legacy_regs`

## Requirements
- R1: After reset, the driver feature mask, the status byte, the cause byte, the queue selector and all page frames read as zero. The config vector and every queue vector read as 0xFFFF. `irqLine`, `msgReq`, `qNotify` and `rdData` are low.
- R2: A read at offset 0 returns `HOST_FEATURES` with bits 24, 28 and 30 forced to one. A write at offset 4 stores the value, except when bit 30 of the value is set: the stored mask is then `FALLBACK_FEATURES`. Offset 4 reads back the stored mask.
- R3: A write at offset 14 updates the queue selector only when the value is below `NUM_QUEUES`. Otherwise the write is dropped. Offset 14 reads back the selector.
- R4: A nonzero write at offset 8 stores the page frame number of the selected queue, and offset 8 reads it back per queue. Offset 12 reads `QUEUE_SIZE` for any queue.
- R5: Writing zero at offset 8, or a value whose low 8 bits are zero at offset 18, returns every register to its R1 state on the next cycle.
- R6: A write at offset 18 keeps only the low 8 bits as the status byte, and offset 18 reads the status back.
- R7: A read at offset 19 returns the cause byte and clears it in the same access. The level line is low from the next cycle, unless an event arrives in that same cycle.
- R8: A queue event sets cause bit 0. A config event sets cause bits 0 and 1. While `msgEnable` is low, `irqLine` equals cause bit 0.
- R9: While `msgEnable` is high, an event produces a one-cycle `msgReq` in the next cycle with `msgVector` set to the queue's vector, or to the config vector for a config event. There is no request when that vector is 0xFFFF, and `irqLine` stays low.
- R10: While `msgEnable` is high, offset 20 is the config vector and offset 22 is the selected queue's vector. A written value below `NUM_VECTORS` is stored. Any other value stores 0xFFFF.
- R11: The device area starts at offset 24 when `msgEnable` is high and at offset 20 when it is low. In that area the access shows in the same cycle on `devReq` with `devOffset` equal to the address minus the start. A read there returns `devRdData`.
- R12: A read at an undefined offset (1, 2, 3, 5 to 7, 9 to 11, 13, 15 to 17, 21, 23) returns all ones, cut to the access size. A write to an undefined or read-only offset (0, 12, 19) changes nothing.
- R13: The access size is `accSize`: 0 is a byte, 1 a halfword, 2 or 3 a word. Write data is cut to that width before any decision is made on it. Read data is cut to that width and is valid on `rdData` in the cycle after the strobe, where it holds until the next read.
- R14: A write at offset 16 with a value below `NUM_QUEUES` gives a one-cycle `qNotify` in the next cycle, with `qNotifyIdx` equal to the value. Larger values give no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| accValid | input | 1 | Host access strobe, one cycle per access |
| accWrite | input | 1 | 1 for write, 0 for read |
| accAddr | input | ADDR_W | Byte offset inside the window |
| accSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| accWdata | input | 32 | Write data, right-aligned |
| rdData | output | 32 | Read data, valid the cycle after a read strobe |
| msgEnable | input | 1 | Message interrupts enabled |
| evtValid | input | 1 | Event from the queue engine |
| evtIsCfg | input | 1 | 1 for a config-change event, 0 for a queue event |
| evtQueue | input | QIDX_W | Queue of a queue event |
| irqLine | output | 1 | Legacy level interrupt |
| msgReq | output | 1 | One-cycle message interrupt request |
| msgVector | output | 16 | Vector of the message request |
| qNotify | output | 1 | One-cycle queue notification |
| qNotifyIdx | output | QIDX_W | Notified queue |
| devReq | output | 1 | Access falls in the device area |
| devWrite | output | 1 | Device area access is a write |
| devOffset | output | ADDR_W | Rebased offset inside the device area |
| devSize | output | 2 | Access size for the device area |
| devWdata | output | 32 | Size-cut write data for the device area |
| devRdData | input | 32 | Device area read data, taken in the strobe cycle |

## Verification
The window is driven with a seeded random mix of reads and writes over every defined, undefined and device-area offset, in all three sizes. Small values, full-width values and values that cut to zero are mixed in, and events and mode flips are interleaved. Small values probe the bounds of the selector, the notification and the vector claim. Values that cut to zero separate a true reset trigger from a nonzero value whose upper bits would be dropped. Flipping the mode between accesses to offsets 20 to 26 separates vector registers from device-area forwarding and checks the shifted rebase. Directed cases cover the capability marker bit, per-queue page frame storage, a read-clear racing against a new event, and a vector of 0xFFFF that suppresses a message request.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef enum logic [3:0] {
    RS_NONE,
    RS_HFEAT,
    RS_GFEAT,
    RS_PFN,
    RS_QNUM,
    RS_QSEL,
    RS_NOTIFY,
    RS_STATUS,
    RS_ISR,
    RS_CVEC,
    RS_QVEC,
    RS_DEV
  } regSel_e;

  // strobes from decode to the register datapath
  typedef struct packed {
    logic        rdEn;
    regSel_e     rdSel;
    logic        wrGfeat;
    logic        wrPfn;
    logic        wrQsel;
    logic        wrStatus;
    logic        wrCvec;
    logic        wrQvec;
    logic        notify;
    logic        rdIsr;
    logic        devReset;
    logic [31:0] wval;
  } ctrlStrb_t;

  localparam int          BAD_FEAT_BIT = 30;
  localparam logic [31:0] FIXED_CAPS   = (32'd1 << 24) | (32'd1 << 28) | (32'd1 << BAD_FEAT_BIT);
  localparam logic [15:0] NO_VECTOR    = 16'hFFFF;

  function automatic logic [31:0] sizeMask(input accSize_e s, input logic [31:0] v);
    case (s)
      SZ_BYTE: sizeMask = {24'h0, v[7:0]};
      SZ_HALF: sizeMask = {16'h0, v[15:0]};
      default: sizeMask = v;
    endcase
  endfunction

endpackage

// File: rtl/vreg_ctrl.sv
module vreg_ctrl
  import vreg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_QUEUES = 4
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [31:0]       accWdata,
  input  logic              msgEnable,
  output ctrlStrb_t         strb,
  output logic              devReq,
  output logic              devWrite,
  output logic [ADDR_W-1:0] devOffset,
  output logic [1:0]        devSize,
  output logic [31:0]       devWdata
);

  localparam logic [ADDR_W-1:0] BASE_MSG = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] BASE_LEG = ADDR_W'(20);

  logic [ADDR_W-1:0] devBase;
  logic              inDev;
  logic [31:0]       wMasked;
  regSel_e           sel;
  logic              doWrite;

  assign devBase = msgEnable ? BASE_MSG : BASE_LEG;
  assign inDev   = accAddr >= devBase;
  assign wMasked = sizeMask(accSize_e'(accSize), accWdata);
  assign doWrite = accValid && accWrite;

  // offset decode; vector slots only exist below the message-mode boundary
  always_comb begin
    sel = RS_NONE;
    if (inDev) begin
      sel = RS_DEV;
    end else begin
      case (accAddr)
        ADDR_W'(0):  sel = RS_HFEAT;
        ADDR_W'(4):  sel = RS_GFEAT;
        ADDR_W'(8):  sel = RS_PFN;
        ADDR_W'(12): sel = RS_QNUM;
        ADDR_W'(14): sel = RS_QSEL;
        ADDR_W'(16): sel = RS_NOTIFY;
        ADDR_W'(18): sel = RS_STATUS;
        ADDR_W'(19): sel = RS_ISR;
        ADDR_W'(20): sel = RS_CVEC;
        ADDR_W'(22): sel = RS_QVEC;
        default:     sel = RS_NONE;
      endcase
    end
  end

  always_comb begin
    strb       = '0;
    strb.wval  = wMasked;
    strb.rdEn  = accValid && !accWrite;
    strb.rdSel = sel;
    strb.rdIsr = accValid && !accWrite && (sel == RS_ISR);
    if (doWrite) begin
      case (sel)
        RS_GFEAT: strb.wrGfeat = 1'b1;
        RS_PFN: begin
          if (wMasked == 32'h0) strb.devReset = 1'b1;
          else                  strb.wrPfn    = 1'b1;
        end
        RS_QSEL:   strb.wrQsel = wMasked < 32'(NUM_QUEUES);
        RS_NOTIFY: strb.notify = wMasked < 32'(NUM_QUEUES);
        RS_STATUS: begin
          if (wMasked[7:0] == 8'h00) strb.devReset = 1'b1;
          else                       strb.wrStatus = 1'b1;
        end
        RS_CVEC: strb.wrCvec = 1'b1;
        RS_QVEC: strb.wrQvec = 1'b1;
        default: ;
      endcase
    end
  end

  assign devReq    = accValid && inDev;
  assign devWrite  = accWrite;
  assign devOffset = accAddr - devBase;
  assign devSize   = accSize;
  assign devWdata  = wMasked;

endmodule

// File: rtl/vreg_data.sv
module vreg_data
  import vreg_pkg::*;
#(
  parameter int          NUM_QUEUES        = 4,
  parameter int          NUM_VECTORS       = 3,
  parameter logic [15:0] QUEUE_SIZE        = 16'd128,
  parameter logic [31:0] HOST_FEATURES     = 32'h0000_0021,
  parameter logic [31:0] FALLBACK_FEATURES = 32'h0000_0000,
  localparam int         QIDX_W            = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [1:0]        accSize,
  input  logic [31:0]       devRdData,
  input  logic              msgEnable,
  input  logic              evtValid,
  input  logic              evtIsCfg,
  input  logic [QIDX_W-1:0] evtQueue,
  output logic [31:0]       rdData,
  output logic              irqLine,
  output logic              msgReq,
  output logic [15:0]       msgVector,
  output logic              qNotify,
  output logic [QIDX_W-1:0] qNotifyIdx
);

  logic [31:0]       gfeatReg;
  logic [7:0]        statusReg;
  logic [7:0]        isrReg;
  logic [QIDX_W-1:0] qselReg;
  logic [15:0]       cvecReg;
  logic [31:0]       pfnReg  [NUM_QUEUES];
  logic [15:0]       qvecReg [NUM_QUEUES];

  logic [7:0]  evtBits;
  logic [15:0] evtVec;
  logic [31:0] rdVal;

  function automatic logic [15:0] vecClaim(input logic [31:0] v);
    vecClaim = (v < 32'(NUM_VECTORS)) ? v[15:0] : NO_VECTOR;
  endfunction

  assign evtBits = !evtValid ? 8'h00 : (evtIsCfg ? 8'h03 : 8'h01);
  assign evtVec  = evtIsCfg ? cvecReg :
                   (32'(evtQueue) < NUM_QUEUES) ? qvecReg[evtQueue] : NO_VECTOR;

  always_ff @(posedge clk) begin
    if (!rstN || strb.devReset) begin
      gfeatReg  <= '0;
      statusReg <= '0;
      isrReg    <= '0;
      qselReg   <= '0;
      cvecReg   <= NO_VECTOR;
      for (int i = 0; i < NUM_QUEUES; i++) begin
        pfnReg[i]  <= '0;
        qvecReg[i] <= NO_VECTOR;
      end
    end else begin
      if (strb.wrGfeat)
        gfeatReg <= strb.wval[BAD_FEAT_BIT] ? FALLBACK_FEATURES : strb.wval;
      if (strb.wrPfn)    pfnReg[qselReg]  <= strb.wval;
      if (strb.wrQsel)   qselReg          <= strb.wval[QIDX_W-1:0];
      if (strb.wrStatus) statusReg        <= strb.wval[7:0];
      if (strb.wrCvec)   cvecReg          <= vecClaim(strb.wval);
      if (strb.wrQvec)   qvecReg[qselReg] <= vecClaim(strb.wval);
      // a new event wins over a read-clear in the same cycle
      isrReg <= (strb.rdIsr ? 8'h00 : isrReg) | evtBits;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RS_HFEAT:  rdVal = HOST_FEATURES | FIXED_CAPS;
      RS_GFEAT:  rdVal = gfeatReg;
      RS_PFN:    rdVal = pfnReg[qselReg];
      RS_QNUM:   rdVal = 32'(QUEUE_SIZE);
      RS_QSEL:   rdVal = 32'(qselReg);
      RS_STATUS: rdVal = 32'(statusReg);
      RS_ISR:    rdVal = 32'(isrReg);
      RS_CVEC:   rdVal = 32'(cvecReg);
      RS_QVEC:   rdVal = 32'(qvecReg[qselReg]);
      RS_DEV:    rdVal = devRdData;
      default:   rdVal = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData     <= '0;
      msgReq     <= 1'b0;
      msgVector  <= '0;
      qNotify    <= 1'b0;
      qNotifyIdx <= '0;
    end else begin
      if (strb.rdEn) rdData <= sizeMask(accSize_e'(accSize), rdVal);
      msgReq     <= evtValid && msgEnable && (evtVec != NO_VECTOR);
      msgVector  <= evtVec;
      qNotify    <= strb.notify;
      qNotifyIdx <= strb.wval[QIDX_W-1:0];
    end
  end

  assign irqLine = !msgEnable && isrReg[0];

  assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.devReset |=> (statusReg == 8'h00 && qselReg == '0 && cvecReg == NO_VECTOR && isrReg == 8'h00));

  assert_isr_read_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdIsr && !evtValid) |=> (isrReg == 8'h00));

  assert_qsel_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    32'(qselReg) < NUM_QUEUES);

  assert_vec_claimed_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cvecReg == NO_VECTOR) || (32'(cvecReg) < NUM_VECTORS));

  assert_msg_has_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    msgReq |-> $past(evtValid && msgEnable));

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));

endmodule

// File: rtl/vdev_legacy_regs.sv
module vdev_legacy_regs
  import vreg_pkg::*;
#(
  parameter int          ADDR_W            = 8,
  parameter int          NUM_QUEUES        = 4,
  parameter int          NUM_VECTORS       = 3,
  parameter logic [15:0] QUEUE_SIZE        = 16'd128,
  parameter logic [31:0] HOST_FEATURES     = 32'h0000_0021,
  parameter logic [31:0] FALLBACK_FEATURES = 32'h0000_0000,
  localparam int         QIDX_W            = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic [31:0]       accWdata,
  output logic [31:0]       rdData,
  input  logic              msgEnable,
  input  logic              evtValid,
  input  logic              evtIsCfg,
  input  logic [QIDX_W-1:0] evtQueue,
  output logic              irqLine,
  output logic              msgReq,
  output logic [15:0]       msgVector,
  output logic              qNotify,
  output logic [QIDX_W-1:0] qNotifyIdx,
  output logic              devReq,
  output logic              devWrite,
  output logic [ADDR_W-1:0] devOffset,
  output logic [1:0]        devSize,
  output logic [31:0]       devWdata,
  input  logic [31:0]       devRdData
);

  ctrlStrb_t strbW;

  vreg_ctrl #(
    .ADDR_W    (ADDR_W),
    .NUM_QUEUES(NUM_QUEUES)
  ) ctrlInst (
    .accValid (accValid),
    .accWrite (accWrite),
    .accAddr  (accAddr),
    .accSize  (accSize),
    .accWdata (accWdata),
    .msgEnable(msgEnable),
    .strb     (strbW),
    .devReq   (devReq),
    .devWrite (devWrite),
    .devOffset(devOffset),
    .devSize  (devSize),
    .devWdata (devWdata)
  );

  vreg_data #(
    .NUM_QUEUES       (NUM_QUEUES),
    .NUM_VECTORS      (NUM_VECTORS),
    .QUEUE_SIZE       (QUEUE_SIZE),
    .HOST_FEATURES    (HOST_FEATURES),
    .FALLBACK_FEATURES(FALLBACK_FEATURES)
  ) dataInst (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strbW),
    .accSize   (accSize),
    .devRdData (devRdData),
    .msgEnable (msgEnable),
    .evtValid  (evtValid),
    .evtIsCfg  (evtIsCfg),
    .evtQueue  (evtQueue),
    .rdData    (rdData),
    .irqLine   (irqLine),
    .msgReq    (msgReq),
    .msgVector (msgVector),
    .qNotify   (qNotify),
    .qNotifyIdx(qNotifyIdx)
  );

endmodule

// File: tb/vdev_legacy_regs_test.sv
`timescale 1ns/1ps
module vdev_legacy_regs_test;

  localparam logic [31:0] HOSTF    = 32'h0000_0021;
  localparam logic [31:0] FALLBACK = 32'h0000_0000;
  localparam int          NQ       = 4;
  localparam int          NV       = 3;
  localparam logic [15:0] QSIZE    = 16'd128;

  logic        clk = 1'b0;
  logic        rstN;
  logic        accValid, accWrite;
  logic [7:0]  accAddr;
  logic [1:0]  accSize;
  logic [31:0] accWdata;
  logic [31:0] rdData;
  logic        msgEnable, evtValid, evtIsCfg;
  logic [1:0]  evtQueue;
  logic        irqLine, msgReq, qNotify;
  logic [15:0] msgVector;
  logic [1:0]  qNotifyIdx;
  logic        devReq, devWrite;
  logic [7:0]  devOffset;
  logic [1:0]  devSize;
  logic [31:0] devWdata, devRdData;

  always #4 clk = ~clk;

  assign devRdData = 32'hC0DE_0000 | {24'h0, devOffset};

  vdev_legacy_regs #(
    .ADDR_W(8), .NUM_QUEUES(NQ), .NUM_VECTORS(NV), .QUEUE_SIZE(QSIZE),
    .HOST_FEATURES(HOSTF), .FALLBACK_FEATURES(FALLBACK)
  ) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accSize(accSize), .accWdata(accWdata), .rdData(rdData),
    .msgEnable(msgEnable), .evtValid(evtValid), .evtIsCfg(evtIsCfg), .evtQueue(evtQueue),
    .irqLine(irqLine), .msgReq(msgReq), .msgVector(msgVector), .qNotify(qNotify),
    .qNotifyIdx(qNotifyIdx), .devReq(devReq), .devWrite(devWrite), .devOffset(devOffset),
    .devSize(devSize), .devWdata(devWdata), .devRdData(devRdData)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  logic [31:0] mGfeat, mStatus32;
  logic [7:0]  mStatus, mIsr;
  logic [1:0]  mQsel;
  logic [15:0] mCvec;
  logic [31:0] mPfn [NQ];
  logic [15:0] mQvec [NQ];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic mReset();
    mGfeat = 0; mStatus = 0; mIsr = 0; mQsel = 0; mCvec = 16'hFFFF;
    for (int i = 0; i < NQ; i++) begin mPfn[i] = 0; mQvec[i] = 16'hFFFF; end
  endtask

  function automatic logic [31:0] maskSz(input logic [1:0] sz, input logic [31:0] v);
    if (sz == 2'd0) return v & 32'h0000_00FF;
    if (sz == 2'd1) return v & 32'h0000_FFFF;
    return v;
  endfunction

  function automatic logic [15:0] claim(input logic [31:0] v);
    return (v < NV) ? v[15:0] : 16'hFFFF;
  endfunction

  function automatic logic [31:0] expRead(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] v;
    int base;
    base = msgEnable ? 24 : 20;
    if (a >= base) v = 32'hC0DE_0000 | {24'h0, 8'(a - base)};
    else begin
      case (a)
        8'd0:  v = HOSTF | 32'h5100_0000;
        8'd4:  v = mGfeat;
        8'd8:  v = mPfn[mQsel];
        8'd12: v = {16'h0, QSIZE};
        8'd14: v = {30'h0, mQsel};
        8'd18: v = {24'h0, mStatus};
        8'd19: v = {24'h0, mIsr};
        8'd20: v = {16'h0, mCvec};
        8'd22: v = {16'h0, mQvec[mQsel]};
        default: v = 32'hFFFF_FFFF;
      endcase
    end
    return maskSz(sz, v);
  endfunction

  task automatic cycle();
    @(posedge clk);
    #4;
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input string req);
    logic [31:0] v, exp;
    int base;
    bit notifyExp;
    base = msgEnable ? 24 : 20;
    v = maskSz(sz, d);
    exp = expRead(a, sz);
    accValid = 1; accWrite = wr; accAddr = a; accSize = sz; accWdata = d;
    #1;
    if (a >= base) begin
      chk("R11 devReq", {31'h0, devReq}, 32'h1);
      chk("R11 devOffset", {24'h0, devOffset}, 32'(a - base));
    end else chk("R11 devReq", {31'h0, devReq}, 32'h0);
    cycle();
    accValid = 0; accWrite = 0;
    if (!wr) begin
      chk(req, rdData, exp);
      if (a == 8'd19 && a < base) mIsr = 0;
    end else begin
      notifyExp = 0;
      if (a < base) begin
        case (a)
          8'd4:  mGfeat = v[30] ? FALLBACK : v;
          8'd8:  if (v == 0) mReset(); else mPfn[mQsel] = v;
          8'd14: if (v < NQ) mQsel = v[1:0];
          8'd16: notifyExp = (v < NQ);
          8'd18: begin mStatus = v[7:0]; if (v[7:0] == 0) mReset(); end
          8'd20: mCvec = claim(v);
          8'd22: mQvec[mQsel] = claim(v);
          default: ;
        endcase
      end
      chk("R14 qNotify", {31'h0, qNotify}, {31'h0, notifyExp});
      if (notifyExp) chk("R14 qNotifyIdx", {30'h0, qNotifyIdx}, {30'h0, v[1:0]});
    end
    chk("R8 irqLine", {31'h0, irqLine}, {31'h0, (!msgEnable && mIsr[0])});
  endtask

  task automatic raise(input bit cfg, input logic [1:0] q);
    logic [15:0] vec;
    bit expReq;
    vec = cfg ? mCvec : mQvec[q];
    expReq = msgEnable && (vec != 16'hFFFF);
    evtValid = 1; evtIsCfg = cfg; evtQueue = q;
    cycle();
    evtValid = 0;
    mIsr = mIsr | (cfg ? 8'h03 : 8'h01);
    chk("R9 msgReq", {31'h0, msgReq}, {31'h0, expReq});
    if (expReq) chk("R9 msgVector", {16'h0, msgVector}, {16'h0, vec});
    chk("R8 irqLine", {31'h0, irqLine}, {31'h0, (!msgEnable && mIsr[0])});
  endtask

  localparam logic [7:0] ADDRS [16] = '{8'd0, 8'd1, 8'd4, 8'd8, 8'd12, 8'd14, 8'd16, 8'd18,
                                        8'd19, 8'd20, 8'd22, 8'd24, 8'd26, 8'd2, 8'd6, 8'd30};

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'd20240611));
    rstN = 0; accValid = 0; accWrite = 0; accAddr = 0; accSize = 0; accWdata = 0;
    msgEnable = 0; evtValid = 0; evtIsCfg = 0; evtQueue = 0;
    mReset();
    repeat (3) @(posedge clk);
    #4;
    rstN = 1;
    // R1: reset state
    chk("R1 rdData", rdData, 32'h0);
    chk("R1 irqLine", {31'h0, irqLine}, 32'h0);
    chk("R1 msgReq", {31'h0, msgReq}, 32'h0);
    chk("R1 qNotify", {31'h0, qNotify}, 32'h0);
    access(0, 8'd4, 2, 0, "R1 gfeat");
    access(0, 8'd14, 1, 0, "R1 qsel");
    access(0, 8'd18, 0, 0, "R1 status");
    access(0, 8'd19, 0, 0, "R1 isr");
    access(0, 8'd8, 2, 0, "R1 pfn");
    msgEnable = 1;
    access(0, 8'd20, 1, 0, "R1 cvec");
    access(0, 8'd22, 1, 0, "R1 qvec");
    msgEnable = 0;
    // R2
    access(0, 8'd0, 2, 0, "R2 host features");
    access(1, 8'd4, 2, 32'h0000_00F3, "R2");
    access(0, 8'd4, 2, 0, "R2 guest features");
    access(1, 8'd4, 2, 32'h4000_0001, "R2");
    access(0, 8'd4, 2, 0, "R2 fallback");
    // R3, R13
    access(1, 8'd14, 1, 2, "R3");
    access(0, 8'd14, 1, 0, "R3 qsel 2");
    access(1, 8'd14, 1, 4, "R3");
    access(0, 8'd14, 1, 0, "R3 qsel out of range ignored");
    access(1, 8'd14, 1, 32'h0001_0001, "R13");
    access(0, 8'd14, 1, 0, "R13 halfword cut");
    // R4
    access(1, 8'd8, 2, 32'h0001_2345, "R4");
    access(1, 8'd14, 1, 2, "R4");
    access(1, 8'd8, 2, 32'h0000_0777, "R4");
    access(1, 8'd14, 1, 1, "R4");
    access(0, 8'd8, 2, 0, "R4 pfn q1");
    access(1, 8'd14, 1, 2, "R4");
    access(0, 8'd8, 2, 0, "R4 pfn q2");
    access(0, 8'd12, 1, 0, "R4 queue size");
    // R6
    access(1, 8'd18, 1, 32'h0000_01A5, "R6");
    access(0, 8'd18, 0, 0, "R6 status low byte");
    // R7, R8
    raise(0, 2'd1);
    access(0, 8'd19, 0, 0, "R7 isr read queue");
    raise(1, 2'd0);
    access(0, 8'd19, 0, 0, "R7 isr read config");
    access(0, 8'd19, 0, 0, "R7 isr cleared");
    // R5: byte write of 0x100 cuts to zero
    access(1, 8'd4, 2, 5, "R5");
    access(1, 8'd18, 0, 32'h0000_0100, "R5");
    access(0, 8'd4, 2, 0, "R5 gfeat after status reset");
    access(0, 8'd14, 1, 0, "R5 qsel after status reset");
    access(1, 8'd14, 1, 1, "R5");
    access(1, 8'd8, 2, 32'h99, "R5");
    access(1, 8'd8, 2, 0, "R5");
    access(0, 8'd14, 1, 0, "R5 qsel after pfn reset");
    access(1, 8'd14, 1, 1, "R5");
    access(0, 8'd8, 2, 0, "R5 pfn after pfn reset");
    access(1, 8'd14, 1, 0, "R5");
    // R10, R9
    msgEnable = 1;
    access(1, 8'd20, 1, 1, "R10");
    access(0, 8'd20, 1, 0, "R10 cvec");
    access(1, 8'd22, 1, 7, "R10");
    access(0, 8'd22, 1, 0, "R10 qvec unclaimable");
    access(1, 8'd22, 1, 2, "R10");
    access(0, 8'd22, 1, 0, "R10 qvec");
    raise(1, 2'd0);
    raise(0, 2'd0);
    raise(0, 2'd3);
    access(0, 8'd19, 0, 0, "R9 isr still collected");
    // R11
    access(0, 8'd24, 2, 0, "R11 dev read base");
    access(0, 8'd26, 2, 0, "R11 dev read +2");
    msgEnable = 0;
    access(0, 8'd20, 2, 0, "R11 dev read legacy base");
    access(0, 8'd22, 2, 0, "R11 dev read legacy +2");
    access(1, 8'd20, 1, 0, "R11");
    msgEnable = 1;
    access(0, 8'd20, 1, 0, "R11 cvec untouched by dev write");
    msgEnable = 0;
    // R12
    access(0, 8'd1, 0, 0, "R12 undefined byte");
    access(0, 8'd2, 1, 0, "R12 undefined half");
    access(0, 8'd16, 2, 0, "R12 notify read");
    access(1, 8'd4, 2, 32'h33, "R12");
    access(1, 8'd2, 2, 0, "R12");
    access(1, 8'd0, 2, 0, "R12");
    access(1, 8'd12, 2, 0, "R12");
    access(0, 8'd4, 2, 0, "R12 gfeat unchanged");
    access(0, 8'd0, 2, 0, "R12 host features unchanged");
    access(0, 8'd12, 1, 0, "R12 queue size unchanged");
    raise(0, 2'd0);
    access(1, 8'd19, 0, 0, "R12");
    access(0, 8'd19, 0, 0, "R12 isr not written");
    // R14
    access(1, 8'd16, 1, 3, "R14");
    access(1, 8'd16, 1, 9, "R14");
    access(1, 8'd16, 0, 32'h0000_0102, "R14");
    // random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom % 10;
      if (r < 2) raise(($urandom % 3) == 0, 2'($urandom % 4));
      else if (r == 2) msgEnable = ~msgEnable;
      else begin
        case ($urandom % 4)
          0: rv = $urandom % 6;
          1: rv = $urandom;
          2: rv = $urandom % 256;
          default: rv = (($urandom % 4) == 0) ? 32'h100 : ($urandom % 4) + 1;
        endcase
        access(($urandom % 2) == 1, ADDRS[$urandom % 16], 2'($urandom % 3), rv, "R13 random");
      end
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule